// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single 16-bit down-counting timer channel driven through a byte-wide register port. Software writes a control byte to choose one of six operating behaviours, then loads a 16-bit start value as two byte writes. The channel decrements once per falling edge of its count clock input. It produces a waveform on its output pin. Depending on the chosen behaviour, that waveform is a level change at terminal count, a one-shot pulse, a periodic strobe, a square wave, or a single-period strobe.

The count clock and the gate input are plain signals sampled by the system clock, so their edges are found synchronously. A start value of zero means a full 65536-count span. Software can freeze the running count with a latch command and then read it back as two bytes, low byte first. A read strobe returns its byte on the cycle that follows.

Top module: `tmr_channel`

## Requirements
- R1: After reset the output pin is high and a two-byte count read returns 0.
- R2: A control byte is accepted only when bits 7:6 are 00. Field 5:4 = 11 selects a behaviour from bits 3:1, with codes 6 and 7 acting as 2 and 3. Field 5:4 = 01 or 10 is ignored, and so is any byte with a nonzero select; such a byte leaves the behaviour and output unchanged.
- R3: Accepting a behaviour clears the stored start value and stops counting. The output goes low for behaviour 0 and high for every other behaviour. Nothing counts until a new value is written.
- R4: The start value is written at address 0 as two bytes, low byte first. The count drops by one on each detected falling edge of the count clock.
- R5: Behaviour 0: the output goes low when the second byte is written and rises after N falling edges (0 gives 65536). It then stays high.
- R6: Behaviour 1: a gate rising edge after a value is written loads it and drives the output low. The output returns high after N falling edges, and a further gate rising edge restarts the span.
- R7: Behaviour 2: the output is low for exactly the count-clock period in which the count is 1, then the count reloads. A value written while running takes effect at the next reload, and a gate rising edge restarts the count.
- R8: Behaviour 3: the count steps by two and the output toggles each time it reaches 2. An odd value acts as value−1, and 0 gives a half period of 32768 edges.
- R9: Behaviour 4: counting starts on the second byte write. After N falling edges the output is low for one count-clock period, then stays high.
- R10: Behaviour 5: as behaviour 4, but the span starts on a gate rising edge, and nothing happens before that edge.
- R11: In behaviours 0 and 4 a gate rising edge changes neither the count nor the output.
- R12: Control byte 0x00 freezes the count. The next two reads at address 0 return the frozen value, low byte first, and later reads return the live count. Read data appears the cycle after the read strobe and is otherwise held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 1 | 0 = count register, 1 = control register |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWrData | input | 8 | Write data byte |
| busRdData | output | 8 | Read data byte, valid the cycle after busRd |
| tmrClk | input | 1 | Count clock, falling edges decrement |
| tmrGate | input | 1 | Gate, rising edges trigger in behaviours 1, 2, 3, 5 |
| tmrOut | output | 1 | Timer output pin |

## Verification
The hardest case to reach is the zero start value in square-wave behaviour. Its first toggle comes only after 32768 count edges. The stimulus reaches it by running the count clock at its fastest rate, one toggle per system cycle, and timing the first output fall. Wrap through zero in behaviour 0 is shown more cheaply, by reading back a count just below 0x10000 after a few edges. The behavioural model in the bench tracks output and read data on every cycle. The explicit checks measure low-time and toggle counts over fixed windows for each behaviour.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    MODE_TC       = 3'd0,
    MODE_ONESHOT  = 3'd1,
    MODE_RATE     = 3'd2,
    MODE_SQUARE   = 3'd3,
    MODE_SWSTROBE = 3'd4,
    MODE_HWSTROBE = 3'd5
  } tmrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     progMode;
    tmrMode_e newMode;
    logic     loadLo;
    logic     loadHi;
    logic     latchCmd;
    logic     rdLo;
    logic     rdHi;
    logic     clkFall;
    logic     gateRise;
  } tmrStb_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BYTE_W-1:1] ctrlBits,
  input  logic              tmrClk,
  input  logic              tmrGate,
  output tmrStb_t           stb,
  output tmrMode_e          curMode
);
  localparam int SEL_HI = BYTE_W - 1;
  localparam int ACC_HI = BYTE_W - 3;

  logic     clkQ, gateQ, wrPtrQ, rdPtrQ;
  tmrMode_e modeQ;
  logic     ctrlWr, cntWr, cntRd, selOk;
  logic [1:0] accField;
  logic [2:0] modeField;
  tmrMode_e mappedMode;

  always_comb begin
    ctrlWr    = busWr && busAddr;
    cntWr     = busWr && !busAddr;
    cntRd     = busRd && !busAddr;
    selOk     = (ctrlBits[SEL_HI -: 2] == 2'b00);
    accField  = ctrlBits[ACC_HI -: 2];
    modeField = ctrlBits[3:1];
    // codes 6 and 7 alias the periodic behaviours 2 and 3
    mappedMode = modeField[1] ? tmrMode_e'({1'b0, modeField[1:0]})
                              : tmrMode_e'(modeField);
  end

  always_comb begin
    stb.progMode = ctrlWr && selOk && (accField == 2'b11);
    stb.newMode  = mappedMode;
    stb.latchCmd = ctrlWr && selOk && (accField == 2'b00);
    stb.loadLo   = cntWr && !wrPtrQ;
    stb.loadHi   = cntWr && wrPtrQ;
    stb.rdLo     = cntRd && !rdPtrQ;
    stb.rdHi     = cntRd && rdPtrQ;
    stb.clkFall  = clkQ && !tmrClk;
    stb.gateRise = !gateQ && tmrGate;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clkQ   <= 1'b0;
      gateQ  <= 1'b0;
      wrPtrQ <= 1'b0;
      rdPtrQ <= 1'b0;
      modeQ  <= MODE_TC;
    end else begin
      clkQ  <= tmrClk;
      gateQ <= tmrGate;
      if (stb.progMode) begin
        modeQ  <= mappedMode;
        wrPtrQ <= 1'b0;
        rdPtrQ <= 1'b0;
      end else begin
        if (cntWr) wrPtrQ <= !wrPtrQ;
        if (cntRd) rdPtrQ <= !rdPtrQ;
      end
    end
  end

  assign curMode = modeQ;
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmrStb_t           stb,
  input  tmrMode_e          curMode,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  output logic              tmrOut,
  output logic [2*BYTE_W-1:0] curCount,
  output logic              running
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0]  presetQ, cntQ, latchQ;
  logic [BYTE_W-1:0] loQ, rdQ;
  logic outQ, runQ, armQ, tcQ, latchVldQ;
  logic [CNT_W-1:0] newVal, evenNew, evenPreset, rdSrc;
  logic gateMode, isSquare;

  always_comb begin
    newVal     = {busWrData, loQ};
    evenNew    = {newVal[CNT_W-1:1], 1'b0};
    evenPreset = {presetQ[CNT_W-1:1], 1'b0};
    rdSrc      = latchVldQ ? latchQ : cntQ;
    isSquare   = (curMode == MODE_SQUARE);
    gateMode   = curMode inside {MODE_ONESHOT, MODE_RATE, MODE_SQUARE, MODE_HWSTROBE};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presetQ   <= '0;
      cntQ      <= '0;
      latchQ    <= '0;
      loQ       <= '0;
      rdQ       <= '0;
      outQ      <= 1'b1;
      runQ      <= 1'b0;
      armQ      <= 1'b0;
      tcQ       <= 1'b0;
      latchVldQ <= 1'b0;
    end else begin
      if (stb.loadLo) loQ <= busWrData;

      // counter: programming > count write > gate trigger > clock edge
      if (stb.progMode) begin
        presetQ <= '0;
        runQ    <= 1'b0;
        armQ    <= 1'b0;
        tcQ     <= 1'b0;
        outQ    <= (stb.newMode != MODE_TC);
      end else if (stb.loadHi) begin
        presetQ <= newVal;
        armQ    <= 1'b1;
        case (curMode)
          MODE_TC: begin
            cntQ <= newVal; outQ <= 1'b0; runQ <= 1'b1; tcQ <= 1'b0;
          end
          MODE_SWSTROBE: begin
            cntQ <= newVal; outQ <= 1'b1; runQ <= 1'b1; tcQ <= 1'b0;
          end
          MODE_RATE, MODE_SQUARE: begin
            if (!runQ) begin
              cntQ <= isSquare ? evenNew : newVal;
              outQ <= 1'b1;
              runQ <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (stb.gateRise && armQ && gateMode) begin
        cntQ <= isSquare ? evenPreset : presetQ;
        runQ <= 1'b1;
        tcQ  <= 1'b0;
        outQ <= (curMode != MODE_ONESHOT);
      end else if (stb.clkFall && runQ) begin
        case (curMode)
          MODE_TC, MODE_ONESHOT: begin
            cntQ <= cntQ - ONE;
            if (cntQ == ONE) begin
              outQ <= 1'b1;
              runQ <= 1'b0;
            end
          end
          MODE_RATE: begin
            if (cntQ == ONE) begin
              cntQ <= presetQ;
              outQ <= 1'b1;
            end else begin
              cntQ <= cntQ - ONE;
              outQ <= (cntQ != TWO);
            end
          end
          MODE_SQUARE: begin
            if (cntQ == TWO) begin
              cntQ <= evenPreset;
              outQ <= !outQ;
            end else begin
              cntQ <= cntQ - TWO;
            end
          end
          default: begin
            if (tcQ) begin
              outQ <= 1'b1;
              runQ <= 1'b0;
              tcQ  <= 1'b0;
            end else begin
              cntQ <= cntQ - ONE;
              if (cntQ == ONE) begin
                outQ <= 1'b0;
                tcQ  <= 1'b1;
              end
            end
          end
        endcase
      end

      if (stb.latchCmd && !latchVldQ) begin
        latchQ    <= cntQ;
        latchVldQ <= 1'b1;
      end else if (stb.rdHi) begin
        latchVldQ <= 1'b0;
      end

      if (stb.rdLo)      rdQ <= rdSrc[BYTE_W-1:0];
      else if (stb.rdHi) rdQ <= rdSrc[CNT_W-1:BYTE_W];
    end
  end

  assign busRdData = rdQ;
  assign tmrOut    = outQ;
  assign curCount  = cntQ;
  assign running   = runQ;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  input  logic              tmrClk,
  input  logic              tmrGate,
  output logic              tmrOut
);
  tmrStb_t  stb;
  tmrMode_e curMode;
  logic [2*BYTE_W-1:0] curCount;
  logic running;

  tmr_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .ctrlBits(busWrData[BYTE_W-1:1]), .tmrClk(tmrClk),
    .tmrGate(tmrGate), .stb(stb), .curMode(curMode)
  );

  tmr_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .curMode(curMode),
    .busWrData(busWrData), .busRdData(busRdData), .tmrOut(tmrOut),
    .curCount(curCount), .running(running)
  );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              progMode,
  input tmrMode_e          newMode,
  input logic              loadHi,
  input logic              clkFall,
  input logic              gateRise,
  input tmrMode_e          curMode,
  input logic [2*BYTE_W-1:0] curCount,
  input logic              running,
  input logic              tmrOut,
  input logic              busRd,
  input logic [BYTE_W-1:0] busRdData
);
  // R3: output level after a behaviour is accepted
  a_r3_prog_low: assert property (@(posedge clk) disable iff (!rst_n)
    progMode && newMode == MODE_TC |=> !tmrOut);
  a_r3_prog_high: assert property (@(posedge clk) disable iff (!rst_n)
    progMode && newMode != MODE_TC |=> tmrOut);

  // R4: count moves only on a load, trigger or clock edge
  a_r4_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !clkFall && !loadHi && !gateRise |=> $stable(curCount));

  // R8: square-wave count stays even while running
  a_r8_square_even: assert property (@(posedge clk) disable iff (!rst_n)
    running && curMode == MODE_SQUARE |-> !curCount[0]);

  // R9: a low output in the strobe behaviours only occurs mid-span
  a_r9_strobe_running: assert property (@(posedge clk) disable iff (!rst_n)
    (curMode == MODE_SWSTROBE || curMode == MODE_HWSTROBE) && !tmrOut |-> running);

  // R11: gate edge does nothing in behaviours 0 and 4
  a_r11_gate_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (curMode == MODE_TC || curMode == MODE_SWSTROBE) && gateRise && !clkFall
      && !loadHi && !progMode |=> $stable(curCount) && $stable(tmrOut));

  // R12: read data held between reads
  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busRd |=> $stable(busRdData));
endmodule

bind tmr_channel tmr_channel_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .progMode(stb.progMode), .newMode(stb.newMode),
  .loadHi(stb.loadHi), .clkFall(stb.clkFall), .gateRise(stb.gateRise),
  .curMode(curMode), .curCount(curCount), .running(running), .tmrOut(tmrOut),
  .busRd(busRd), .busRdData(busRdData)
);

// File: tb/tmr_channel_tb.sv
`timescale 1ns/1ps
module tmr_channel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busAddr = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic tmrClk = 1'b0, tmrGate = 1'b0;
  logic tmrOut;

  int checks = 0, failures = 0;
  int halfP = 2, divCnt = 0;
  int cycles = 0;
  bit modelOn = 0;

  always #10 clk = ~clk;

  tmr_channel u_dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData), .tmrClk(tmrClk),
    .tmrGate(tmrGate), .tmrOut(tmrOut)
  );

  // count clock generator
  always @(negedge clk) begin
    divCnt = divCnt + 1;
    if (divCnt >= halfP) begin
      divCnt = 0;
      tmrClk <= ~tmrClk;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mMode, mPreset, mCnt, mOut, mRun, mArm, mTc, mLatch, mLatchV, mLo, mRd;
  int mWp, mRp, mPc, mPg;

  function automatic string modeTag(input int m);
    case (m)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      3: return "R8";
      4: return "R9";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    int fall, rise, prog, latchC, lo, hi, v, old, src, nm;
    if (!rst_n) begin
      mMode = 0; mPreset = 0; mCnt = 0; mOut = 1; mRun = 0; mArm = 0; mTc = 0;
      mLatch = 0; mLatchV = 0; mLo = 0; mRd = 0; mWp = 0; mRp = 0; mPc = 0; mPg = 0;
    end else begin
      fall = (mPc == 1 && tmrClk == 0);
      rise = (mPg == 0 && tmrGate == 1);
      prog = 0; latchC = 0; lo = 0; hi = 0;
      if (busWr && busAddr && busWrData[7:6] == 2'b00) begin
        if (busWrData[5:4] == 2'b11) prog = 1;
        else if (busWrData[5:4] == 2'b00) latchC = 1;
      end
      if (busWr && !busAddr) begin
        if (mWp == 0) lo = 1; else hi = 1;
        mWp = 1 - mWp;
      end
      if (busRd && !busAddr) begin
        src = mLatchV ? mLatch : mCnt;
        if (mRp == 0) mRd = src % 256;
        else begin mRd = src / 256; mLatchV = 0; end
        mRp = 1 - mRp;
      end
      if (latchC && !mLatchV) begin mLatch = mCnt; mLatchV = 1; end
      if (lo) mLo = busWrData;
      if (prog) begin
        nm = busWrData[3:1];
        if (nm >= 6) nm = nm - 4;
        mPreset = 0; mRun = 0; mArm = 0; mTc = 0;
        mOut = (nm != 0); mMode = nm; mWp = 0; mRp = 0;
      end else if (hi) begin
        v = busWrData * 256 + mLo;
        mPreset = v; mArm = 1;
        if (mMode == 0) begin mCnt = v; mOut = 0; mRun = 1; mTc = 0; end
        else if (mMode == 4) begin mCnt = v; mOut = 1; mRun = 1; mTc = 0; end
        else if ((mMode == 2 || mMode == 3) && !mRun) begin
          mCnt = (mMode == 3) ? v - (v % 2) : v; mOut = 1; mRun = 1;
        end
      end else if (rise && mArm && (mMode == 1 || mMode == 2 || mMode == 3 || mMode == 5)) begin
        mCnt = (mMode == 3) ? mPreset - (mPreset % 2) : mPreset;
        mRun = 1; mTc = 0; mOut = (mMode == 1) ? 0 : 1;
      end else if (fall && mRun) begin
        old = mCnt;
        if (mMode <= 1) begin
          mCnt = (old + 65535) % 65536;
          if (old == 1) begin mOut = 1; mRun = 0; end
        end else if (mMode == 2) begin
          if (old == 1) begin mCnt = mPreset; mOut = 1; end
          else begin mCnt = (old + 65535) % 65536; mOut = (mCnt == 1) ? 0 : 1; end
        end else if (mMode == 3) begin
          if (old == 2) begin mCnt = mPreset - (mPreset % 2); mOut = 1 - mOut; end
          else mCnt = (old + 65534) % 65536;
        end else begin
          if (mTc) begin mOut = 1; mRun = 0; mTc = 0; end
          else begin
            mCnt = (old + 65535) % 65536;
            if (old == 1) begin mOut = 0; mTc = 1; end
          end
        end
      end
      mPc = tmrClk; mPg = tmrGate;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (modelOn) begin
      chk(tmrOut === mOut[0], modeTag(mMode), tmrOut, mOut);
      chk(busRdData === mRd[7:0], "R12", busRdData, mRd);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busWrite(input logic a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic wrCtrl(input logic [7:0] d);
    busWrite(1'b1, d);
  endtask

  task automatic wrCnt(input int v);
    busWrite(1'b0, v[7:0]);
    busWrite(1'b0, v[15:8]);
  endtask

  task automatic rdCnt(output int v);
    busAddr = 1'b0; busRd = 1'b1;
    @(negedge clk);
    v = busRdData;
    @(negedge clk);
    busRd = 1'b0;
    @(negedge clk);
    v = v;
    v = v + busRdData * 256;
  endtask

  task automatic pulseGate();
    tmrGate = 1'b1; idle(2);
    tmrGate = 1'b0; idle(1);
  endtask

  task automatic watch(input int n, output int lows, output int edges);
    logic prev;
    lows = 0; edges = 0; prev = tmrOut;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!tmrOut) lows++;
      if (tmrOut != prev) edges++;
      prev = tmrOut;
    end
  endtask

  initial begin
    int v, v2, lows, edges, wait_n;
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    modelOn = 1;

    // R1: reset state
    chk(tmrOut === 1'b1, "R1", tmrOut, 1);
    rdCnt(v);
    chk(v == 0, "R1", v, 0);

    // R3: program behaviour 0 -> output low
    wrCtrl(8'h30); idle(1);
    chk(tmrOut === 1'b0, "R3", tmrOut, 0);
    // R4: decrement from 0x1234
    wrCnt(16'h1234); idle(30);
    rdCnt(v);
    chk(v < 16'h1234 && v > 16'h1234 - 20, "R4", v, 16'h1234);
    // R11: gate edge in behaviour 0
    pulseGate();
    chk(tmrOut === 1'b0, "R11", tmrOut, 0);
    // R5: count 5 completes
    wrCnt(5); idle(5 * 4 + 6);
    chk(tmrOut === 1'b1, "R5", tmrOut, 1);
    idle(20);
    chk(tmrOut === 1'b1, "R5", tmrOut, 1);
    // R5: zero start wraps to a full span
    wrCnt(0); idle(14);
    rdCnt(v);
    chk(v > 16'hFF00, "R5", v, 16'hFFFD);

    // R2: ignored control bytes keep behaviour 0
    wrCtrl(8'h72);
    wrCtrl(8'h12);
    wrCnt(3); idle(1);
    chk(tmrOut === 1'b0, "R2", tmrOut, 0);
    idle(20);

    // R6: one-shot
    wrCtrl(8'h32);
    wrCnt(4); idle(10);
    chk(tmrOut === 1'b1, "R6", tmrOut, 1);
    pulseGate();
    chk(tmrOut === 1'b0, "R6", tmrOut, 0);
    idle(6);
    pulseGate();
    idle(30);
    chk(tmrOut === 1'b1, "R6", tmrOut, 1);

    // R7: rate generator
    wrCtrl(8'h34);
    wrCnt(3);
    watch(48, lows, edges);
    chk(lows >= 12 && lows <= 20, "R7", lows, 16);
    wrCnt(5); idle(40);
    pulseGate(); idle(30);

    // R8: square wave, even and odd starts
    wrCtrl(8'h36);
    wrCnt(6);
    watch(96, lows, edges);
    chk(edges >= 7 && edges <= 9, "R8", edges, 8);
    wrCtrl(8'h36);
    wrCnt(5);
    watch(96, lows, edges);
    chk(edges >= 11 && edges <= 13, "R8", edges, 12);

    // R2: code 7 acts as square wave
    wrCtrl(8'h3E);
    wrCnt(4);
    watch(96, lows, edges);
    chk(edges >= 11 && edges <= 13, "R2", edges, 12);

    // R9: software strobe, one period low
    wrCtrl(8'h38);
    wrCnt(3);
    watch(60, lows, edges);
    chk(lows == 4, "R9", lows, 4);
    pulseGate(); idle(1);
    chk(tmrOut === 1'b1, "R11", tmrOut, 1);

    // R10: hardware strobe
    wrCtrl(8'h3A);
    wrCnt(2);
    watch(40, lows, edges);
    chk(lows == 0, "R10", lows, 0);
    tmrGate = 1'b1;
    watch(40, lows, edges);
    chk(lows == 4, "R10", lows, 4);
    tmrGate = 1'b0; idle(2);

    // R12: latch then live reads
    wrCtrl(8'h34);
    wrCnt(16'h0100); idle(8);
    wrCtrl(8'h00); idle(40);
    rdCnt(v);
    rdCnt(v2);
    chk(v2 < v, "R12", v2, v);
    chk(v <= 16'h0100 && v > 16'h00F0, "R12", v, 16'h00FE);

    // R8: zero start -> half period of 32768 edges at fastest count clock
    halfP = 1;
    wrCtrl(8'h36);
    wrCnt(0);
    wait_n = 0;
    while (tmrOut === 1'b1 && wait_n < 70000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(wait_n >= 65530 && wait_n <= 65545, "R8", wait_n, 65536);
    idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule